// File: doc/BRIEF.md
# Scripted Memory-Mapped Bus Master

This block is a self-running bus master for a 32-bit Avalon memory-mapped port. Once reset is released it waits a fixed start delay and then issues four single-beat accesses in a fixed order: two writes, then two reads. Each access keeps its command on the port until the slave drops waitrequest, and only then does it complete. No software control is involved.

Writes always use the lowest byte lane. Each read carries its own byte-enable pattern. When a read completes, the master captures the returned word and raises a one-cycle strobe, along with a small index that says which of the two scripted reads produced the word. After the final access a done flag goes high and stays high. The block suits bring-up tests, slave exercisers, or any boot-time sequence that has to poke a few registers without a processor.

Between accesses the port is quiet: read and write are low and the address, byte-enable and write-data buses are zero. Exactly one such quiet cycle separates two consecutive accesses.

Top module: `avmm_script_master`

## Requirements
- R1: After the last cycle with rst high, read and write stay low on the first three rising edges. The first command appears right after the third edge.
- R2: The accesses run in this order: write 0x0000000F to address 0, write 0x00000008 to address 1, read address 2 with byteenable 4'b0001, read address 3 with byteenable 4'b0011. Every write uses byteenable 4'b0001.
- R3: While a command is on the port and waitrequest is high, address, byteenable, read, write and writedata hold their values from the previous cycle.
- R4: An access completes on the first rising edge at which waitrequest is low. A command that is presented with waitrequest already low lasts exactly one cycle.
- R5: On the edge where a read completes, readdata is captured. In the following cycle rd_strobe is high for exactly one cycle, rd_word holds the captured word, and rd_index is 0 for the read of address 2 and 1 for the read of address 3.
- R6: After every completed access there is exactly one cycle with read and write both low before the next command. Whenever read and write are both low, address, byteenable and writedata are zero.
- R7: done rises in the cycle after the fourth access completes. It then stays high and no further command is issued until reset.
- R8: rst is synchronous and active high. The cycle after an edge with rst high shows read, write, done and rd_strobe all low, and the script restarts from the start delay.
- R9: read and write are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| address | output | 32 | Word address of the current command |
| byteenable | output | 4 | Byte lanes of the current command |
| read | output | 1 | Read command |
| write | output | 1 | Write command |
| writedata | output | 32 | Write data |
| waitrequest | input | 1 | Slave stall; the command holds while high |
| readdata | input | 32 | Slave read data, sampled when a read completes |
| rd_strobe | output | 1 | One-cycle pulse after each completed read |
| rd_index | output | 2 | Which scripted read the captured word belongs to |
| rd_word | output | 32 | Captured read word |
| done | output | 1 | Script finished; sticky until reset |

## Verification
The assertions check the following on every cycle: command stability during stalls, the quiet cycle after each completion and its zeroed buses, mutual exclusion of read and write, the write byte lane, the pulse shape of the read strobe and its link to a read completing, the stickiness of done, and the cleared state after reset. Some behaviour can only be shown by the bench's scenarios: the exact start delay, the script order and its values, the edge on which each access ends under a given number of wait states, and the captured words and indices. To cover these, the bench sweeps every combination of zero to three wait states on each of the four accesses and compares the full port trace, cycle by cycle, against a timeline it computes from that combination.

// File: rtl/avmm_script_master.sv
module avmm_script_master #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BE_W        = 4,
  parameter int START_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] address,
  output logic [BE_W-1:0]   byteenable,
  output logic              read,
  output logic              write,
  output logic [DATA_W-1:0] writedata,
  input  logic              waitrequest,
  input  logic [DATA_W-1:0] readdata,
  output logic              rd_strobe,
  output logic [1:0]        rd_index,
  output logic [DATA_W-1:0] rd_word,
  output logic              done
);
  localparam int CNT_W     = $clog2(START_DELAY + 1);
  localparam int LAST_STEP = 3;

  typedef enum logic [1:0] {ST_DELAY, ST_CMD, ST_GAP, ST_DONE} st_t;

  st_t              state;
  logic [CNT_W-1:0] dly;
  logic [1:0]       step;

  logic              cur_rd;
  logic [ADDR_W-1:0] cur_addr;
  logic [BE_W-1:0]   cur_be;
  logic [DATA_W-1:0] cur_data;

  always_comb begin
    cur_rd   = 1'b0;
    cur_addr = '0;
    cur_be   = BE_W'(1);
    cur_data = '0;
    case (step)
      2'd0: cur_data = DATA_W'(32'h0000_000F);
      2'd1: begin cur_addr = ADDR_W'(1); cur_data = DATA_W'(32'h0000_0008); end
      2'd2: begin cur_rd = 1'b1; cur_addr = ADDR_W'(2); end
      default: begin cur_rd = 1'b1; cur_addr = ADDR_W'(3); cur_be = BE_W'(3); end
    endcase
  end

  wire active = (state == ST_CMD);

  assign read       = active &  cur_rd;
  assign write      = active & ~cur_rd;
  assign address    = active ? cur_addr : '0;
  assign byteenable = active ? cur_be   : '0;
  assign writedata  = (active & ~cur_rd) ? cur_data : '0;
  assign done       = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_DELAY;
      dly       <= '0;
      step      <= '0;
      rd_strobe <= 1'b0;
      rd_index  <= '0;
      rd_word   <= '0;
    end else begin
      rd_strobe <= 1'b0;
      case (state)
        ST_DELAY:
          if (dly == CNT_W'(START_DELAY - 1)) state <= ST_CMD;
          else dly <= dly + 1'b1;
        ST_CMD:
          if (!waitrequest) begin
            if (cur_rd) begin
              rd_strobe <= 1'b1;
              rd_word   <= readdata;
              rd_index  <= step - 2'd2;
            end
            if (step == 2'(LAST_STEP)) state <= ST_DONE;
            else begin
              step  <= step + 1'b1;
              state <= ST_GAP;
            end
          end
        ST_GAP:  state <= ST_CMD;
        default: state <= ST_DONE;
      endcase
    end
  end
endmodule

module avmm_script_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] address,
  input logic [BE_W-1:0]   byteenable,
  input logic              read,
  input logic              write,
  input logic [DATA_W-1:0] writedata,
  input logic              waitrequest,
  input logic              rd_strobe,
  input logic              done
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    ((read || write) && waitrequest) |=> ($stable(address) && $stable(byteenable) &&
      $stable(read) && $stable(write) && $stable(writedata))); // R3
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (rst)
    !(read && write)); // R9
  AST_GAP_AFTER: assert property (@(posedge clk) disable iff (rst)
    ((read || write) && !waitrequest) |=> (!read && !write)); // R6
  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!read && !write) |-> (address == '0 && byteenable == '0 && writedata == '0)); // R6
  AST_WR_LANE: assert property (@(posedge clk) disable iff (rst)
    write |-> (byteenable == BE_W'(1))); // R2
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> !rd_strobe); // R5
  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (read && !waitrequest) |=> rd_strobe); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !read && !write)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!read && !write && !done && !rd_strobe)); // R8
endmodule

bind avmm_script_master avmm_script_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
) u_chk (
  .clk(clk), .rst(rst), .address(address), .byteenable(byteenable),
  .read(read), .write(write), .writedata(writedata),
  .waitrequest(waitrequest), .rd_strobe(rd_strobe), .done(done)
);

// File: tb/avmm_script_master_bench.sv
module avmm_script_master_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] address;
  logic [3:0]  byteenable;
  logic        read, write;
  logic [31:0] writedata;
  logic        waitrequest;
  logic [31:0] readdata;
  logic        rd_strobe;
  logic [1:0]  rd_index;
  logic [31:0] rd_word;
  logic        done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int run_id = 0;
  int wl[4];
  int acc = 0;
  int scnt = 0;

  always #(CLK_P/2) clk = ~clk;

  avmm_script_master u_avmm_script_master (
    .clk(clk), .rst(rst), .address(address), .byteenable(byteenable),
    .read(read), .write(write), .writedata(writedata),
    .waitrequest(waitrequest), .readdata(readdata),
    .rd_strobe(rd_strobe), .rd_index(rd_index), .rd_word(rd_word), .done(done)
  );

  function automatic logic [31:0] pat(input logic [31:0] a, input int r);
    return 32'hC0DE_0000 ^ (32'(r) << 4) ^ a;
  endfunction

  assign waitrequest = (read || write) && (acc < 4) && (scnt < wl[acc < 4 ? acc : 0]);
  assign readdata    = read ? pat(address, run_id) : 32'h0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      acc  <= 0;
      scnt <= 0;
    end else if ((read || write) && waitrequest) begin
      scnt <= scnt + 1;
    end else if (read || write) begin
      scnt <= 0;
      acc  <= acc + 1;
    end
  end

  task automatic summary_and_finish();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    total = total + 1;
    bad   = bad + 1;
    $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
    summary_and_finish();
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s run=%0d: actual=%h expected=%h", req, what, run_id, act, exp);
    end
  endtask

  task automatic run(input int w0, input int w1, input int w2, input int w3);
    int cs[4];
    int fin;
    wl[0] = w0; wl[1] = w1; wl[2] = w2; wl[3] = w3;
    cs[0] = 3;
    for (int k = 1; k < 4; k++) cs[k] = cs[k-1] + wl[k-1] + 2;
    fin = cs[3] + wl[3] + 1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R8", "read",      32'(read),      32'h0);
    chk("R8", "write",     32'(write),     32'h0);
    chk("R8", "done",      32'(done),      32'h0);
    chk("R8", "rd_strobe", 32'(rd_strobe), 32'h0);
    rst = 1'b0;
    for (int n = 1; n <= fin + 2; n++) begin
      int act_k;
      string rq;
      logic [31:0] ea, ed;
      logic [3:0]  eb;
      logic        er, ew, es;
      logic [1:0]  ei;
      @(negedge clk);
      act_k = -1;
      for (int k = 0; k < 4; k++) if (n >= cs[k] && n <= cs[k] + wl[k]) act_k = k;
      er = 0; ew = 0; ea = 0; eb = 0; ed = 0;
      if (act_k >= 0) begin
        ea = 32'(act_k);
        er = (act_k >= 2);
        ew = !er;
        eb = (act_k == 3) ? 4'b0011 : 4'b0001;
        ed = (act_k == 0) ? 32'hF : (act_k == 1) ? 32'h8 : 32'h0;
      end
      if (n < 3) rq = "R1";
      else if (act_k >= 0 && n > cs[act_k]) rq = "R3";
      else if (act_k >= 0) rq = "R2";
      else if (n > fin) rq = "R7";
      else rq = "R6";
      chk(rq, "read",       32'(read),       32'(er));
      chk(rq, "write",      32'(write),      32'(ew));
      chk(rq, "address",    address,         ea);
      chk(rq, "byteenable", 32'(byteenable), 32'(eb));
      chk(rq, "writedata",  writedata,       ed);
      chk("R9", "rd_and_wr", 32'(read && write), 32'h0);
      es = 0; ei = 0;
      for (int k = 2; k < 4; k++) if (n == cs[k] + wl[k] + 1) begin es = 1; ei = 2'(k - 2); end
      chk("R4", "rd_strobe", 32'(rd_strobe), 32'(es));
      if (es) begin
        chk("R5", "rd_index", 32'(rd_index), 32'(ei));
        chk("R5", "rd_word",  rd_word, pat(32'(ei) + 32'd2, run_id));
      end
      chk("R7", "done", 32'(done), 32'(n >= fin));
    end
  endtask

  initial begin
    wl[0] = 0; wl[1] = 0; wl[2] = 0; wl[3] = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            run_id = run_id + 1;
            run(a, b, c, d);
          end
    summary_and_finish();
  end
endmodule